// File: doc/BRIEF.md
# NAND Command and Address Front End with Page Region Pointer

This block is the device-side front end of a NAND array whose pages hold 512 main bytes plus 16 spare bytes. A host writes bytes on an 8-bit bus together with a command-latch or address-latch qualifier and a write strobe. The block decodes command bytes into an operation, keeps a region pointer that picks which third of the page the single column byte addresses, and assembles a full column and row address from the address bytes that follow. On read strobes it serves the two identification bytes or the status byte supplied by the program/erase engine.

The pointer replaces the two high column bits: the main area's lower half (A), its upper half (B), or the spare area (C). A selection of B lasts for one addressed operation only and then falls back to A; a selection of C remains until another pointer command. At reset the block is in read mode with the pointer on A, so a host may issue address bytes directly, and successive address sequences reuse the last operation without a new command. The array, its timing and its analog behaviour lie outside this block; the write and read strobes are single-cycle pulses synchronous to `clk`.

Top module: `nand_cmd_front`

## Requirements
- R1: A write strobe with the command qualifier high and the address qualifier low decodes the byte: 00h, 01h, 50h and FFh give op_code 0 (read), 80h gives 1 (program), 60h gives 2 (erase), 90h gives 3 (identify), 70h gives 4 (status); any other byte leaves op_code and area_sel unchanged.
- R2: A write strobe with both qualifiers high, or with both low, changes no op_code, area_sel, col_addr or row_addr and raises no addr_done.
- R3: area_sel is 0 (A) after 00h or FFh, 1 (B) after 01h, 2 (C) after 50h; other commands keep it.
- R4: In read or program, the third address byte completes the sequence: addr_done is high for exactly the one cycle after that strobe, in which col_addr holds the first byte in A, 256 plus the first byte in B, or 512 plus the first byte's low four bits in C.
- R5: row_addr is the second byte in bits 7:0 and the low six bits of the third byte in bits 13:8; after completion the next address byte starts a new sequence with the same operation and pointer.
- R6: In erase, two address bytes form row_addr the same way, addr_done pulses after the second, and col_addr keeps its value.
- R7: After reset op_code is 0, area_sel 0, col_addr 0, row_addr 0, io_out 0 and addr_done 0.
- R8: After a completed sequence with area_sel 1, area_sel returns to 0 on the next cycle unless a command arrives then; area_sel 2 is kept across sequences.
- R9: After 90h and an address byte of 00h, read strobes return ECh, then E6h, then 00h; a nonzero address byte gives 00h on reads; identify mode lasts until the next decoded command.
- R10: In status mode a read strobe returns the status_in value present with the strobe.
- R11: io_out changes only in the cycle after a read strobe and otherwise holds; a read in read, program or erase mode returns 00h.
- R12: A decoded command in the middle of an address sequence restarts it, so the next address byte is again the first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_latch | input | 1 | Byte qualifier: command |
| addr_latch | input | 1 | Byte qualifier: address |
| wr_strobe | input | 1 | One-cycle write pulse taking io_in |
| rd_strobe | input | 1 | One-cycle read pulse requesting a byte |
| io_in | input | 8 | Host byte |
| status_in | input | 8 | Status byte from the program/erase engine |
| io_out | output | 8 | Byte returned on read |
| op_code | output | 3 | Decoded operation |
| area_sel | output | 2 | Page region pointer (0 A, 1 B, 2 C) |
| col_addr | output | 10 | Assembled column address |
| row_addr | output | 14 | Assembled page address |
| addr_done | output | 1 | One-cycle pulse when an address sequence completes |

## Verification
Random address sequences under each pointer command, with random column and row bytes and an occasional program command, separate the three column offset rules and show the one-shot fall-back of region B against the persistence of region C. Interleaved identify and status reads with random status values tell the two read sources apart and confirm that any new command leaves identify mode. Directed cases cover the power-up read without a command, the two illegal qualifier combinations, an unknown command, a restart in mid-sequence, the two-byte erase sequence and a nonzero identify address.

// File: rtl/nand_fe_pkg.sv
package nand_fe_pkg;
    localparam int IO_W = 8;

    typedef enum logic [2:0] {
        OP_READ   = 3'd0,
        OP_PROG   = 3'd1,
        OP_ERASE  = 3'd2,
        OP_ID     = 3'd3,
        OP_STATUS = 3'd4
    } op_e;

    typedef enum logic [1:0] {
        AREA_A = 2'd0,
        AREA_B = 2'd1,
        AREA_C = 2'd2
    } area_e;

    localparam logic [IO_W-1:0] CMD_PTR_A  = 8'h00;
    localparam logic [IO_W-1:0] CMD_PTR_B  = 8'h01;
    localparam logic [IO_W-1:0] CMD_PTR_C  = 8'h50;
    localparam logic [IO_W-1:0] CMD_PROG   = 8'h80;
    localparam logic [IO_W-1:0] CMD_ERASE  = 8'h60;
    localparam logic [IO_W-1:0] CMD_ID     = 8'h90;
    localparam logic [IO_W-1:0] CMD_STATUS = 8'h70;
    localparam logic [IO_W-1:0] CMD_RESET  = 8'hFF;

    localparam logic [IO_W-1:0] ID_BYTE0 = 8'hEC;
    localparam logic [IO_W-1:0] ID_BYTE1 = 8'hE6;
endpackage

// File: rtl/nand_cmd_decode.sv
module nand_cmd_decode
    import nand_fe_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cmd_stb,
    input  logic [IO_W-1:0] io_in,
    input  logic            seq_done,
    output op_e             op,
    output area_e           area,
    output logic            new_cmd
);
    typedef struct packed {
        op_e   op;
        area_e area;
    } dec_s;

    dec_s dec_d, dec_q;

    always_comb begin
        dec_d   = dec_q;
        new_cmd = 1'b0;
        // one-shot region B falls back after its sequence completes
        if (seq_done && dec_q.area == AREA_B) begin
            dec_d.area = AREA_A;
        end
        if (cmd_stb) begin
            new_cmd = 1'b1;
            case (io_in)
                CMD_PTR_A, CMD_RESET: begin
                    dec_d.op   = OP_READ;
                    dec_d.area = AREA_A;
                end
                CMD_PTR_B: begin
                    dec_d.op   = OP_READ;
                    dec_d.area = AREA_B;
                end
                CMD_PTR_C: begin
                    dec_d.op   = OP_READ;
                    dec_d.area = AREA_C;
                end
                CMD_PROG:   dec_d.op = OP_PROG;
                CMD_ERASE:  dec_d.op = OP_ERASE;
                CMD_ID:     dec_d.op = OP_ID;
                CMD_STATUS: dec_d.op = OP_STATUS;
                default: begin
                    dec_d   = dec_q;
                    new_cmd = 1'b0;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dec_q <= '{op: OP_READ, area: AREA_A};
        end else begin
            dec_q <= dec_d;
        end
    end

    assign op   = dec_q.op;
    assign area = dec_q.area;
endmodule

// File: rtl/nand_addr_asm.sv
module nand_addr_asm
    import nand_fe_pkg::*;
#(
    parameter int MAIN_BYTES  = 512,
    parameter int SPARE_BYTES = 16,
    parameter int ROW_W       = 14,
    localparam int COL_W      = $clog2(MAIN_BYTES + SPARE_BYTES),
    localparam int HALF       = MAIN_BYTES / 2,
    localparam int SPARE_W    = $clog2(SPARE_BYTES),
    localparam int ROW_CYC    = (ROW_W + IO_W - 1) / IO_W,
    localparam int CNT_W      = $clog2(ROW_CYC + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             addr_stb,
    input  logic             new_cmd,
    input  logic [IO_W-1:0]  io_in,
    input  op_e              op,
    input  area_e            area,
    output logic [COL_W-1:0] col_addr,
    output logic [ROW_W-1:0] row_addr,
    output logic             done
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic [COL_W-1:0] col_pend;
        logic [ROW_W-1:0] row_pend;
        logic [COL_W-1:0] col;
        logic [ROW_W-1:0] row;
        logic             done;
    } asm_s;

    asm_s asm_d, asm_q;
    logic [COL_W-1:0] col_calc;
    logic             takes_addr;
    logic             is_erase;
    logic             is_last;
    int               row_idx;

    always_comb begin
        case (area)
            AREA_B:  col_calc = COL_W'(HALF) + COL_W'(io_in);
            AREA_C:  col_calc = COL_W'(MAIN_BYTES) + COL_W'(io_in[SPARE_W-1:0]);
            default: col_calc = COL_W'(io_in);
        endcase
    end

    always_comb begin
        asm_d      = asm_q;
        asm_d.done = 1'b0;
        is_erase   = (op == OP_ERASE);
        takes_addr = (op == OP_READ) || (op == OP_PROG) || is_erase;
        is_last    = is_erase ? (asm_q.cnt == CNT_W'(ROW_CYC - 1))
                              : (asm_q.cnt == CNT_W'(ROW_CYC));
        row_idx    = is_erase ? int'(asm_q.cnt) : int'(asm_q.cnt) - 1;
        if (new_cmd) begin
            asm_d.cnt = '0;
        end else if (addr_stb && takes_addr) begin
            if (!is_erase && asm_q.cnt == '0) begin
                asm_d.col_pend = col_calc;
            end else begin
                for (int j = 0; j < ROW_W; j++) begin
                    if (j / IO_W == row_idx) begin
                        asm_d.row_pend[j] = io_in[j % IO_W];
                    end
                end
            end
            if (is_last) begin
                asm_d.cnt  = '0;
                asm_d.done = 1'b1;
                asm_d.row  = asm_d.row_pend;
                if (!is_erase) begin
                    asm_d.col = asm_d.col_pend;
                end
            end else begin
                asm_d.cnt = asm_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            asm_q <= '0;
        end else begin
            asm_q <= asm_d;
        end
    end

    assign col_addr = asm_q.col;
    assign row_addr = asm_q.row;
    assign done     = asm_q.done;
endmodule

// File: rtl/nand_read_mux.sv
module nand_read_mux
    import nand_fe_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            rd_stb,
    input  logic            addr_stb,
    input  logic            new_cmd,
    input  logic [IO_W-1:0] io_in,
    input  logic [IO_W-1:0] status_in,
    input  op_e             op,
    output logic [IO_W-1:0] io_out
);
    typedef struct packed {
        logic            id_on;
        logic [1:0]      idx;
        logic [IO_W-1:0] dout;
    } rd_s;

    rd_s rd_d, rd_q;

    always_comb begin
        rd_d = rd_q;
        if (new_cmd) begin
            rd_d.id_on = 1'b0;
            rd_d.idx   = '0;
        end else if (addr_stb && op == OP_ID) begin
            rd_d.id_on = (io_in == '0);
            rd_d.idx   = '0;
        end
        if (rd_stb) begin
            if (op == OP_STATUS) begin
                rd_d.dout = status_in;
            end else if (op == OP_ID && rd_q.id_on) begin
                case (rd_q.idx)
                    2'd0:    rd_d.dout = ID_BYTE0;
                    2'd1:    rd_d.dout = ID_BYTE1;
                    default: rd_d.dout = '0;
                endcase
                if (rd_q.idx != 2'd2) begin
                    rd_d.idx = rd_q.idx + 1'b1;
                end
            end else begin
                rd_d.dout = '0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_q <= '0;
        end else begin
            rd_q <= rd_d;
        end
    end

    assign io_out = rd_q.dout;
endmodule

// File: rtl/nand_cmd_front.sv
module nand_cmd_front
    import nand_fe_pkg::*;
#(
    parameter int MAIN_BYTES  = 512,
    parameter int SPARE_BYTES = 16,
    parameter int ROW_W       = 14,
    localparam int COL_W      = $clog2(MAIN_BYTES + SPARE_BYTES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_latch,
    input  logic             addr_latch,
    input  logic             wr_strobe,
    input  logic             rd_strobe,
    input  logic [7:0]       io_in,
    input  logic [7:0]       status_in,
    output logic [7:0]       io_out,
    output logic [2:0]       op_code,
    output logic [1:0]       area_sel,
    output logic [COL_W-1:0] col_addr,
    output logic [ROW_W-1:0] row_addr,
    output logic             addr_done
);
    logic  cmd_stb, addr_stb, new_cmd;
    op_e   op;
    area_e area;

    // a byte is taken only when exactly one qualifier is high
    assign cmd_stb  = wr_strobe &&  cmd_latch && !addr_latch;
    assign addr_stb = wr_strobe && !cmd_latch &&  addr_latch;

    nand_cmd_decode u_dec (
        .clk      (clk),
        .rst_n    (rst_n),
        .cmd_stb  (cmd_stb),
        .io_in    (io_in),
        .seq_done (addr_done),
        .op       (op),
        .area     (area),
        .new_cmd  (new_cmd)
    );

    nand_addr_asm #(
        .MAIN_BYTES  (MAIN_BYTES),
        .SPARE_BYTES (SPARE_BYTES),
        .ROW_W       (ROW_W)
    ) u_asm (
        .clk      (clk),
        .rst_n    (rst_n),
        .addr_stb (addr_stb),
        .new_cmd  (new_cmd),
        .io_in    (io_in),
        .op       (op),
        .area     (area),
        .col_addr (col_addr),
        .row_addr (row_addr),
        .done     (addr_done)
    );

    nand_read_mux u_rd (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_stb    (rd_strobe),
        .addr_stb  (addr_stb),
        .new_cmd   (new_cmd),
        .io_in     (io_in),
        .status_in (status_in),
        .op        (op),
        .io_out    (io_out)
    );

    assign op_code  = op;
    assign area_sel = area;
endmodule

// File: rtl/nand_cmd_front_chk.sv
module nand_cmd_front_chk #(
    parameter int MAIN_BYTES  = 512,
    parameter int SPARE_BYTES = 16,
    parameter int ROW_W       = 14,
    localparam int COL_W      = $clog2(MAIN_BYTES + SPARE_BYTES)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cmd_latch,
    input logic             addr_latch,
    input logic             wr_strobe,
    input logic             rd_strobe,
    input logic [7:0]       io_out,
    input logic [2:0]       op_code,
    input logic [1:0]       area_sel,
    input logic [COL_W-1:0] col_addr,
    input logic             addr_done
);
    assert_area_legal_R3: assert property (@(posedge clk) disable iff (!rst_n)
        area_sel != 2'd3);

    assert_col_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
        addr_done |-> (int'(col_addr) < MAIN_BYTES + SPARE_BYTES));

    assert_done_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
        addr_done |=> !addr_done);

    assert_done_op_R6: assert property (@(posedge clk) disable iff (!rst_n)
        addr_done |-> (op_code <= 3'd2));

    assert_b_reverts_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (addr_done && area_sel == 2'd1 && !(wr_strobe && cmd_latch && !addr_latch))
        |=> area_sel == 2'd0);

    assert_out_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_strobe |=> $stable(io_out));
endmodule

bind nand_cmd_front nand_cmd_front_chk #(
    .MAIN_BYTES  (MAIN_BYTES),
    .SPARE_BYTES (SPARE_BYTES),
    .ROW_W       (ROW_W)
) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .cmd_latch  (cmd_latch),
    .addr_latch (addr_latch),
    .wr_strobe  (wr_strobe),
    .rd_strobe  (rd_strobe),
    .io_out     (io_out),
    .op_code    (op_code),
    .area_sel   (area_sel),
    .col_addr   (col_addr),
    .addr_done  (addr_done)
);

// File: tb/nand_cmd_front_test.sv
module nand_cmd_front_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cle = 1'b0, ale = 1'b0, wr = 1'b0, rd = 1'b0;
    logic [7:0]  din = '0, stat = '0;
    logic [7:0]  io_out;
    logic [2:0]  op_code;
    logic [1:0]  area_sel;
    logic [9:0]  col_addr;
    logic [13:0] row_addr;
    logic        addr_done;
    int          checks = 0, errors = 0;

    always #5 clk = ~clk;

    nand_cmd_front uut (
        .clk(clk), .rst_n(rst_n), .cmd_latch(cle), .addr_latch(ale),
        .wr_strobe(wr), .rd_strobe(rd), .io_in(din), .status_in(stat),
        .io_out(io_out), .op_code(op_code), .area_sel(area_sel),
        .col_addr(col_addr), .row_addr(row_addr), .addr_done(addr_done)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // every task starts and ends at a falling edge
    task automatic wr_byte(input logic c, input logic a, input logic [7:0] b);
        cle = c; ale = a; din = b; wr = 1'b1;
        @(negedge clk);
        wr = 1'b0; cle = 1'b0; ale = 1'b0;
    endtask

    task automatic cmd(input logic [7:0] b);  wr_byte(1'b1, 1'b0, b); endtask
    task automatic addr(input logic [7:0] b); wr_byte(1'b0, 1'b1, b); endtask

    task automatic rd_byte();
        rd = 1'b1;
        @(negedge clk);
        rd = 1'b0;
    endtask

    task automatic idle(); @(negedge clk); endtask

    function automatic logic [9:0] exp_col(input int ptr, input logic [7:0] b);
        case (ptr)
            1:       return 10'(256 + int'(b));
            2:       return 10'(512 + int'(b[3:0]));
            default: return 10'(b);
        endcase
    endfunction

    function automatic logic [13:0] exp_row(input logic [7:0] lo, input logic [7:0] hi);
        return {hi[5:0], lo};
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        int ptr;
        logic [7:0] c, r0, r1;
        logic [2:0] op_exp;
        logic [9:0] col_hold;
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        idle();

        // R7 reset state
        chk("R7 op", 32'(op_code), 0);
        chk("R7 area", 32'(area_sel), 0);
        chk("R7 col", 32'(col_addr), 0);
        chk("R7 row", 32'(row_addr), 0);
        chk("R7 io_out", 32'(io_out), 0);
        chk("R7 done", 32'(addr_done), 0);

        // R4 R5 read at power-up with no command
        addr(8'h3C); addr(8'h12); addr(8'hFF);
        chk("R4 done at power-up", 32'(addr_done), 1);
        chk("R4 col region A", 32'(col_addr), 32'h3C);
        chk("R5 row", 32'(row_addr), 32'h3F12);
        idle();
        chk("R4 done one cycle", 32'(addr_done), 0);

        // R2 illegal qualifier combinations
        wr_byte(1'b1, 1'b1, 8'h50);
        chk("R2 both high area", 32'(area_sel), 0);
        chk("R2 both high op", 32'(op_code), 0);
        wr_byte(1'b0, 1'b0, 8'h60);
        chk("R2 neither op", 32'(op_code), 0);
        wr_byte(1'b1, 1'b1, 8'h01); wr_byte(1'b0, 1'b0, 8'h02);
        chk("R2 no done", 32'(addr_done), 0);
        chk("R2 col kept", 32'(col_addr), 32'h3C);
        chk("R2 row kept", 32'(row_addr), 32'h3F12);

        // R1 unknown command
        cmd(8'h50); cmd(8'h33);
        chk("R1 unknown keeps op", 32'(op_code), 0);
        chk("R3 unknown keeps area C", 32'(area_sel), 2);

        // R12 restart mid-sequence, R3 C persists
        addr(8'h11); addr(8'h22); cmd(8'h50);
        addr(8'hA7); addr(8'h01); addr(8'h02);
        chk("R12 restart col", 32'(col_addr), 32'(10'd519));
        chk("R12 restart row", 32'(row_addr), 32'h0201);
        idle();
        chk("R8 C persists", 32'(area_sel), 2);
        // R5 next sequence without command
        addr(8'h05);
        chk("R5 no done after one byte", 32'(addr_done), 0);
        addr(8'h44); addr(8'h81);
        chk("R5 new sequence col", 32'(col_addr), 32'(10'd517));
        chk("R5 new sequence row", 32'(row_addr), 32'h0144);

        // R6 erase
        cmd(8'h60);
        chk("R1 erase op", 32'(op_code), 2);
        addr(8'h9A);
        chk("R6 no done after one", 32'(addr_done), 0);
        addr(8'hC3);
        chk("R6 done", 32'(addr_done), 1);
        chk("R6 row", 32'(row_addr), 32'h039A);
        chk("R6 col kept", 32'(col_addr), 32'(10'd517));

        // R9 identify
        cmd(8'h90);
        chk("R1 id op", 32'(op_code), 3);
        addr(8'h00);
        rd_byte(); chk("R9 first id", 32'(io_out), 32'hEC);
        idle(); idle();
        chk("R11 io_out holds", 32'(io_out), 32'hEC);
        rd_byte(); chk("R9 second id", 32'(io_out), 32'hE6);
        rd_byte(); chk("R9 third id", 32'(io_out), 32'h00);
        cmd(8'h90); addr(8'h05);
        rd_byte(); chk("R9 nonzero address", 32'(io_out), 32'h00);

        // R10 status, then id mode left
        stat = 8'hA5; cmd(8'h70);
        chk("R1 status op", 32'(op_code), 4);
        rd_byte(); chk("R10 status byte", 32'(io_out), 32'hA5);
        cmd(8'h90); cmd(8'h00); rd_byte();
        chk("R9 left on new command", 32'(io_out), 32'h00);
        chk("R3 00h area A", 32'(area_sel), 0);

        // R8 B one-shot, R11 read in read mode
        cmd(8'h01);
        chk("R3 01h area B", 32'(area_sel), 1);
        addr(8'h10); addr(8'h00); addr(8'h00);
        chk("R4 col region B", 32'(col_addr), 32'(10'd272));
        chk("R8 B held during done", 32'(area_sel), 1);
        idle();
        chk("R8 B reverts", 32'(area_sel), 0);
        stat = 8'h5A; cmd(8'h70); rd_byte(); cmd(8'h00); rd_byte();
        chk("R11 read mode gives 0", 32'(io_out), 0);
        cmd(8'hFF);
        chk("R3 FFh op", 32'(op_code), 0);

        // randomized sequences
        ptr = 0;
        for (int it = 0; it < 300; it++) begin
            int k;
            k = int'($urandom % 3);
            cmd(k == 0 ? 8'h00 : (k == 1 ? 8'h01 : 8'h50));
            ptr = k;
            op_exp = 3'd0;
            if ($urandom % 4 == 0) begin
                cmd(8'h80);
                op_exp = 3'd1;
            end
            c = 8'($urandom); r0 = 8'($urandom); r1 = 8'($urandom);
            addr(c); addr(r0); addr(r1);
            chk("R4 random done", 32'(addr_done), 1);
            chk("R4 random col", 32'(col_addr), 32'(exp_col(ptr, c)));
            chk("R5 random row", 32'(row_addr), 32'(exp_row(r0, r1)));
            chk("R1 random op", 32'(op_code), 32'(op_exp));
            idle();
            if (ptr == 1) ptr = 0;
            chk("R8 random area", 32'(area_sel), 32'(ptr));
            col_hold = col_addr;
            if (it % 5 == 0) begin
                stat = 8'($urandom);
                cmd(8'h70); rd_byte();
                chk("R10 random status", 32'(io_out), 32'(stat));
            end else if (it % 5 == 1) begin
                cmd(8'h90); addr(8'h00); rd_byte();
                chk("R9 random id0", 32'(io_out), 32'hEC);
                rd_byte();
                chk("R9 random id1", 32'(io_out), 32'hE6);
                chk("R9 col untouched", 32'(col_addr), 32'(col_hold));
            end
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule